// File: doc/BRIEF.md
# Four-Stage Pipelined Floating-Point Adder

This block adds or subtracts two floating-point operands and accepts one new operation on every clock. Each operand has three parts. The sign is one bit, with 1 meaning negative. The exponent is an unsigned biased integer of `EXP_W` bits. The mantissa is a `MAN_W`-bit fraction read as 0.m, and its most significant bit is 1 whenever the value is nonzero. An operand whose mantissa is all zeros is zero, whatever its sign and exponent fields hold.

The work is split into four stages, each closed by a register:

1. The exponents are compared. The larger one becomes the provisional result exponent, and the operand that owns it is routed to the "large" path.
2. The other mantissa is shifted right by the exponent gap. Bits shifted out are dropped.
3. The effective add or subtract is performed on the two magnitudes.
4. The sum is renormalised, either one place to the right or several places to the left, and the exponent is adjusted to match.

A valid flag travels with each operation. Exponent overflow saturates the result. Exponent underflow flushes the result to zero. There is no rounding and there are no special values.

Top module: `fpa_pipe4`

## Requirements
- R1: `out_valid` rises exactly four clock edges after an edge that samples `in_valid` high. Back-to-back operations come out back-to-back and in order, and idle cycles in the input stream show up as idle cycles at the output.
- R2: An operand whose mantissa is zero adds nothing to the result, whatever its sign and exponent. For the exponent comparison, its exponent is taken as 0.
- R3: The result starts from the larger of the two effective exponents. When the exponents are equal, the first operand is taken as the larger. The mantissa of the other operand is shifted right by the exponent difference, and the bits shifted out are discarded.
- R4: When the exponent difference is `MAN_W` or more, the smaller operand aligns to zero.
- R5: With `in_sub`=1 the block computes a − b, which it does by inverting the sign of b. With `in_sub`=0 it computes a + b.
- R6: When the effective signs match, the aligned magnitudes are added and the result takes that common sign.
- R7: When the effective signs differ, the smaller aligned magnitude is subtracted from the larger, and the result takes the sign of the larger magnitude.
- R8: A sum that carries past the top mantissa bit is shifted right by one place, and the exponent is raised by one.
- R9: A nonzero sum with k leading zeros is shifted left by k places, and the exponent is lowered by k.
- R10: A zero magnitude result comes out as canonical zero: sign 0, exponent 0 and mantissa 0.
- R11: If the exponent would pass its all-ones value, the output saturates to exponent all-ones and mantissa all-ones, and the sign is kept.
- R12: If the left shift would take the exponent below 0, the output is canonical zero.
- R13: Every valid nonzero output has its mantissa MSB set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operation present on the inputs |
| in_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| a_sign | input | 1 | Sign of operand a |
| a_exp | input | EXP_W | Biased exponent of operand a |
| a_man | input | MAN_W | Fraction mantissa of operand a |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | EXP_W | Biased exponent of operand b |
| b_man | input | MAN_W | Fraction mantissa of operand b |
| out_valid | output | 1 | Result present on the outputs |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result biased exponent |
| out_man | output | MAN_W | Normalised result mantissa |

## Verification
The bench runs a small configuration and sweeps every operand pairing, covering every exponent, every normalised mantissa and zero, both signs and both operations. That sweep reaches these cases:
- Equal-exponent subtraction, where the second magnitude is the larger. A design that keyed the sign on the exponent order alone would return the wrong sign here.
- Cancellation to zero, where a design without a canonical zero would leak a stale exponent or a negative sign.
- Carries at the top exponent, where a wrapping design would return a tiny value instead of a saturated one.
- Deep left shifts from small exponents, where a design that ignored underflow would wrap into a huge exponent.

A paced run with bubbles checks that the valid flag stays aligned with its data.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  // Effective operation selected in the magnitude stage.
  typedef enum logic {
    EFF_ADD = 1'b0,
    EFF_SUB = 1'b1
  } eff_op_e;

  function automatic eff_op_e eff_op(input logic sign_x, input logic sign_y);
    return (sign_x == sign_y) ? EFF_ADD : EFF_SUB;
  endfunction

endpackage

// File: rtl/fpa_cmp_stage.sv
module fpa_cmp_stage #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sub,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [MAN_W-1:0] a_man,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [MAN_W-1:0] b_man,
  output logic             s1_valid,
  output logic             s1_big_sign,
  output logic [MAN_W-1:0] s1_big_man,
  output logic             s1_sml_sign,
  output logic [MAN_W-1:0] s1_sml_man,
  output logic [EXP_W-1:0] s1_shamt,
  output logic [EXP_W-1:0] s1_exp
);

  logic [EXP_W-1:0] ea_eff, eb_eff;
  logic             sb_eff;
  logic             a_wins;
  logic             big_sign_d, sml_sign_d;
  logic [MAN_W-1:0] big_man_d, sml_man_d;
  logic [EXP_W-1:0] shamt_d, exp_d;

  always_comb begin
    ea_eff = (a_man == '0) ? '0 : a_exp;
    eb_eff = (b_man == '0) ? '0 : b_exp;
    sb_eff = b_sign ^ in_sub;
    a_wins = (ea_eff >= eb_eff);
    if (a_wins) begin
      big_sign_d = a_sign;
      big_man_d  = a_man;
      sml_sign_d = sb_eff;
      sml_man_d  = b_man;
      shamt_d    = ea_eff - eb_eff;
      exp_d      = ea_eff;
    end else begin
      big_sign_d = sb_eff;
      big_man_d  = b_man;
      sml_sign_d = a_sign;
      sml_man_d  = a_man;
      shamt_d    = eb_eff - ea_eff;
      exp_d      = eb_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_big_sign <= big_sign_d;
      s1_big_man  <= big_man_d;
      s1_sml_sign <= sml_sign_d;
      s1_sml_man  <= sml_man_d;
      s1_shamt    <= shamt_d;
      s1_exp      <= exp_d;
    end
  end

endmodule

// File: rtl/fpa_align_stage.sv
module fpa_align_stage #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic             s1_big_sign,
  input  logic [MAN_W-1:0] s1_big_man,
  input  logic             s1_sml_sign,
  input  logic [MAN_W-1:0] s1_sml_man,
  input  logic [EXP_W-1:0] s1_shamt,
  input  logic [EXP_W-1:0] s1_exp,
  output logic             s2_valid,
  output logic             s2_big_sign,
  output logic [MAN_W-1:0] s2_big_man,
  output logic             s2_sml_sign,
  output logic [MAN_W-1:0] s2_sml_man,
  output logic [EXP_W-1:0] s2_exp
);

  logic [MAN_W-1:0] aligned_d;

  always_comb begin
    if (int'(s1_shamt) >= MAN_W) begin
      aligned_d = '0;
    end else begin
      aligned_d = s1_sml_man >> s1_shamt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_big_sign <= s1_big_sign;
      s2_big_man  <= s1_big_man;
      s2_sml_sign <= s1_sml_sign;
      s2_sml_man  <= aligned_d;
      s2_exp      <= s1_exp;
    end
  end

endmodule

// File: rtl/fpa_addsub_stage.sv
module fpa_addsub_stage
  import fpa_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s2_valid,
  input  logic             s2_big_sign,
  input  logic [MAN_W-1:0] s2_big_man,
  input  logic             s2_sml_sign,
  input  logic [MAN_W-1:0] s2_sml_man,
  input  logic [EXP_W-1:0] s2_exp,
  output logic             s3_valid,
  output logic             s3_sign,
  output logic [MAN_W:0]   s3_sum,
  output logic [EXP_W-1:0] s3_exp
);

  eff_op_e        op;
  logic           sign_d;
  logic [MAN_W:0] sum_d;

  always_comb begin
    op = eff_op(s2_big_sign, s2_sml_sign);
    if (op == EFF_ADD) begin
      sum_d  = {1'b0, s2_big_man} + {1'b0, s2_sml_man};
      sign_d = s2_big_sign;
    end else if (s2_big_man >= s2_sml_man) begin
      sum_d  = {1'b0, s2_big_man - s2_sml_man};
      sign_d = s2_big_sign;
    end else begin
      sum_d  = {1'b0, s2_sml_man - s2_big_man};
      sign_d = s2_sml_sign;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_valid <= 1'b0;
    end else begin
      s3_valid <= s2_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_valid) begin
      s3_sign <= sign_d;
      s3_sum  <= sum_d;
      s3_exp  <= s2_exp;
    end
  end

endmodule

// File: rtl/fpa_norm_stage.sv
module fpa_norm_stage #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s3_valid,
  input  logic             s3_sign,
  input  logic [MAN_W:0]   s3_sum,
  input  logic [EXP_W-1:0] s3_exp,
  output logic             out_valid,
  output logic             out_sign,
  output logic [EXP_W-1:0] out_exp,
  output logic [MAN_W-1:0] out_man
);

  localparam int LZ_W = $clog2(MAN_W + 1);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  logic [LZ_W-1:0]  lz;
  logic             lz_found;
  logic             sign_d;
  logic [EXP_W-1:0] exp_d;
  logic [MAN_W-1:0] man_d;

  // Leading-zero count over the fraction part of the sum.
  always_comb begin
    lz       = '0;
    lz_found = 1'b0;
    for (int i = MAN_W - 1; i >= 0; i--) begin
      if (!lz_found) begin
        if (s3_sum[i]) begin
          lz_found = 1'b1;
        end else begin
          lz = lz + LZ_W'(1);
        end
      end
    end
  end

  always_comb begin
    sign_d = s3_sign;
    exp_d  = s3_exp;
    man_d  = s3_sum[MAN_W-1:0];
    if (s3_sum == '0) begin
      sign_d = 1'b0;
      exp_d  = '0;
      man_d  = '0;
    end else if (s3_sum[MAN_W]) begin
      if (s3_exp == EXP_MAX) begin
        exp_d = EXP_MAX;
        man_d = '1;
      end else begin
        exp_d = s3_exp + EXP_W'(1);
        man_d = s3_sum[MAN_W:1];
      end
    end else if (int'(s3_exp) < int'(lz)) begin
      sign_d = 1'b0;
      exp_d  = '0;
      man_d  = '0;
    end else begin
      exp_d = s3_exp - EXP_W'(lz);
      man_d = s3_sum[MAN_W-1:0] << lz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= s3_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s3_valid) begin
      out_sign <= sign_d;
      out_exp  <= exp_d;
      out_man  <= man_d;
    end
  end

endmodule

// File: rtl/fpa_pipe4.sv
module fpa_pipe4 #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sub,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [MAN_W-1:0] a_man,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [MAN_W-1:0] b_man,
  output logic             out_valid,
  output logic             out_sign,
  output logic [EXP_W-1:0] out_exp,
  output logic [MAN_W-1:0] out_man
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  logic             s1_valid, s1_big_sign, s1_sml_sign;
  logic [MAN_W-1:0] s1_big_man, s1_sml_man;
  logic [EXP_W-1:0] s1_shamt, s1_exp;
  logic             s2_valid, s2_big_sign, s2_sml_sign;
  logic [MAN_W-1:0] s2_big_man, s2_sml_man;
  logic [EXP_W-1:0] s2_exp;
  logic             s3_valid, s3_sign;
  logic [MAN_W:0]   s3_sum;
  logic [EXP_W-1:0] s3_exp;

  fpa_cmp_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_sub(in_sub),
    .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
    .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
    .s1_valid(s1_valid), .s1_big_sign(s1_big_sign), .s1_big_man(s1_big_man),
    .s1_sml_sign(s1_sml_sign), .s1_sml_man(s1_sml_man),
    .s1_shamt(s1_shamt), .s1_exp(s1_exp)
  );

  fpa_align_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .clk(clk), .rst_n(rst_sync_n), .s1_valid(s1_valid),
    .s1_big_sign(s1_big_sign), .s1_big_man(s1_big_man),
    .s1_sml_sign(s1_sml_sign), .s1_sml_man(s1_sml_man),
    .s1_shamt(s1_shamt), .s1_exp(s1_exp),
    .s2_valid(s2_valid), .s2_big_sign(s2_big_sign), .s2_big_man(s2_big_man),
    .s2_sml_sign(s2_sml_sign), .s2_sml_man(s2_sml_man), .s2_exp(s2_exp)
  );

  fpa_addsub_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_addsub (
    .clk(clk), .rst_n(rst_sync_n), .s2_valid(s2_valid),
    .s2_big_sign(s2_big_sign), .s2_big_man(s2_big_man),
    .s2_sml_sign(s2_sml_sign), .s2_sml_man(s2_sml_man), .s2_exp(s2_exp),
    .s3_valid(s3_valid), .s3_sign(s3_sign), .s3_sum(s3_sum), .s3_exp(s3_exp)
  );

  fpa_norm_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .clk(clk), .rst_n(rst_sync_n), .s3_valid(s3_valid),
    .s3_sign(s3_sign), .s3_sum(s3_sum), .s3_exp(s3_exp),
    .out_valid(out_valid), .out_sign(out_sign),
    .out_exp(out_exp), .out_man(out_man)
  );

endmodule

// File: rtl/fpa_pipe4_chk.sv
module fpa_pipe4_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             in_valid,
  input logic             s3_valid,
  input logic [MAN_W:0]   s3_sum,
  input logic [EXP_W-1:0] s3_exp,
  input logic             out_valid,
  input logic             out_sign,
  input logic [EXP_W-1:0] out_exp,
  input logic [MAN_W-1:0] out_man
);

  logic [3:0] vtrack;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vtrack <= '0;
    end else begin
      vtrack <= {vtrack[2:0], in_valid};
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid == vtrack[3]);

  assert_msb_set_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_man != '0) |-> out_man[MAN_W-1]);

  assert_canon_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_man == '0) |-> (out_exp == '0 && !out_sign));

  assert_carry_inc_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s3_valid && s3_sum[MAN_W] && s3_exp != '1) |=> out_exp == $past(s3_exp) + EXP_W'(1));

  assert_saturate_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s3_valid && s3_sum[MAN_W] && s3_exp == '1) |=> (out_exp == '1 && out_man == '1));

  assert_left_dec_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s3_valid && !s3_sum[MAN_W] && s3_sum != '0) |=> (out_man == '0 || out_exp <= $past(s3_exp)));

endmodule

bind fpa_pipe4 fpa_pipe4_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .in_valid(in_valid),
  .s3_valid(s3_valid), .s3_sum(s3_sum), .s3_exp(s3_exp),
  .out_valid(out_valid), .out_sign(out_sign),
  .out_exp(out_exp), .out_man(out_man)
);

// File: tb/test_fpa_pipe4.sv
module test_fpa_pipe4;

  localparam int CLK_PERIOD = 10;
  localparam int EW = 3;
  localparam int MW = 4;
  localparam int EMAX = (1 << EW) - 1;

  logic          clk;
  logic          rst_n;
  logic          in_valid, in_sub;
  logic          a_sign, b_sign;
  logic [EW-1:0] a_exp, b_exp;
  logic [MW-1:0] a_man, b_man;
  logic          out_valid, out_sign;
  logic [EW-1:0] out_exp;
  logic [MW-1:0] out_man;

  int checks = 0;
  int failures = 0;
  int n_in = 0;
  int n_out = 0;
  logic mon_en = 1'b0;

  int    exp_q[$];
  string tag_q[$];

  int mans[9] = '{0, 8, 9, 10, 11, 12, 13, 14, 15};

  fpa_pipe4 #(.EXP_W(EW), .MAN_W(MW)) i_fpa_pipe4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
    .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
    .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
    .out_valid(out_valid), .out_sign(out_sign),
    .out_exp(out_exp), .out_man(out_man)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Arithmetic model of the requirements; returns packed {sign,exp,man} and a tag.
  function automatic void model(input int as, input int ae, input int am,
                                input int bs, input int be, input int bm, input int sub,
                                output int res, output string tag);
    int ea, eb, sbe, bgs, bgm, bge, sms, smm, sme, d, al, s, sg, e, m, lz;
    ea  = (am == 0) ? 0 : ae;             // R2
    eb  = (bm == 0) ? 0 : be;
    sbe = bs ^ sub;                       // R5
    if (ea >= eb) begin
      bgs = as; bgm = am; bge = ea; sms = sbe; smm = bm; sme = eb;
    end else begin
      bgs = sbe; bgm = bm; bge = eb; sms = as; smm = am; sme = ea;
    end
    d  = bge - sme;                       // R3
    al = (d >= MW) ? 0 : (smm >> d);      // R4
    if (bgs == sms) begin s = bgm + al; sg = bgs; end            // R6
    else if (bgm >= al) begin s = bgm - al; sg = bgs; end        // R7
    else begin s = al - bgm; sg = sms; end
    lz = 0;
    if (s == 0) begin
      sg = 0; e = 0; m = 0; tag = "R10";
    end else if (s >= (1 << MW)) begin
      if (bge + 1 > EMAX) begin
        e = EMAX; m = (1 << MW) - 1; tag = "R11";
      end else begin
        e = bge + 1; m = s >> 1; tag = "R8";
      end
    end else begin
      while ((s << lz) < (1 << (MW - 1))) lz++;
      if (bge < lz) begin
        sg = 0; e = 0; m = 0; tag = "R12";
      end else begin
        e = bge - lz; m = s << lz;
        if (lz > 0) tag = "R9";
        else if (d >= MW && smm != 0) tag = "R4";
        else if (am == 0 || bm == 0) tag = "R2";
        else if (d > 0) tag = "R3";
        else if (sub != 0) tag = "R5";
        else if (bgs != sms) tag = "R7";
        else tag = "R6";
      end
    end
    res = (sg << (EW + MW)) | (e << MW) | m;
  endfunction

  task automatic drive_op(input int as, input int ae, input int am,
                          input int bs, input int be, input int bm, input int sub);
    int    r;
    string t;
    @(negedge clk);
    a_sign = as[0]; a_exp = ae[EW-1:0]; a_man = am[MW-1:0];
    b_sign = bs[0]; b_exp = be[EW-1:0]; b_man = bm[MW-1:0];
    in_sub = sub[0];
    in_valid = 1'b1;
    model(as, ae, am, bs, be, bm, sub, r, t);
    exp_q.push_back(r);
    tag_q.push_back(t);
    n_in++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Output monitor (R1 ordering, R13 normalisation, value per tag)
  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      int    got, want;
      string t;
      n_out++;
      checks++;
      got = {29'd0, out_sign, out_exp, out_man};
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R1 unexpected output actual=%0h expected=none", got);
      end else begin
        want = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got != want) begin
          failures++;
          $display("FAIL %s actual=%0h expected=%0h", t, got, want);
        end
      end
      checks++;
      if (out_man != '0 && !out_man[MW-1]) begin
        failures++;
        $display("FAIL R13 actual man=%0h expected msb set", out_man);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    in_valid = 1'b0; in_sub = 1'b0;
    a_sign = 1'b0; a_exp = '0; a_man = '0;
    b_sign = 1'b0; b_exp = '0; b_man = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset out_valid actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 idle out_valid actual=%b expected=0", out_valid);
    end
    mon_en = 1'b1;

    // Paced stream with bubbles (R1)
    for (int i = 0; i < 600; i++) begin
      if (i % 3 == 0) idle();
      drive_op(i % 2, (i / 2) % 8, mans[(i / 16) % 9],
               (i / 3) % 2, (i * 5) % 8, mans[(i * 7) % 9], (i / 7) % 2);
    end
    idle();

    // Exhaustive back-to-back sweep (R2..R13)
    for (int sub = 0; sub < 2; sub++)
      for (int as = 0; as < 2; as++)
        for (int ae = 0; ae <= EMAX; ae++)
          for (int ai = 0; ai < 9; ai++)
            for (int bs = 0; bs < 2; bs++)
              for (int be = 0; be <= EMAX; be++)
                for (int bi = 0; bi < 9; bi++)
                  drive_op(as, ae, mans[ai], bs, be, mans[bi], sub);
    idle();

    repeat (10) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || n_out != n_in) begin
      failures++;
      $display("FAIL R1 outputs actual=%0d expected=%0d", n_out, n_in);
    end
    summary();
    $finish;
  end

endmodule